// File: doc/BRIEF.md
# Atomic Read-Modify-Write Bus Master

This block is a bus master that updates one word on a Wishbone classic bus atomically. A single request gives an address, the byte lanes to read, the byte lanes to write, a 2-bit operation and its operand and mask. The master reads the word and computes the new value from it. It then writes that value back to the same address. The cycle signal stays high from the first strobe to the last acknowledge, so an arbiter cannot hand the bus to another master between the read and the write. When the write is acknowledged, the master pulses `done` for one clock. At that point `old_data` holds the value read and `new_data` holds the value written.

The controller has four states. In IDLE the bus is quiet, and an asserted `req_valid` moves it to READ. READ drives a read strobe, and a sampled acknowledge moves it to GAP. GAP is a master wait state: cycle stays high and strobe is low. A sampled low acknowledge moves it to WRITE. WRITE drives the write strobe, and a sampled acknowledge returns the controller to IDLE, dropping cycle and strobe together. An acknowledge that the slave holds high after the read keeps the controller in GAP, so it is never taken as the acknowledge of the write.

Top module: `rmw_master`

## Requirements
- R1: While `rst_n` is low, and after reset, `bus_cyc`, `bus_stb`, `bus_we`, `busy` and `done` are low.
- R2: The clock edge that samples `req_valid` high in IDLE is followed by a read phase. In that phase `bus_cyc`=1, `bus_stb`=1, `bus_we`=0, `bus_adr`=`req_addr` and `bus_sel`=`req_rd_sel`.
- R3: The word on `bus_dat_r` is captured at the edge that samples `bus_ack` high in the read phase. Bytes whose bit in `req_rd_sel` is 0 (bit i covers bits 8i+7..8i) are captured as zero. The result appears on `old_data`.
- R4: The new value is computed from the captured word. `req_op`=0 sets bits (old OR operand). 1 clears bits (old AND NOT operand). 2 replaces the bits under `req_mask` with the operand. 3 writes the old value back unchanged.
- R5: After the read acknowledge, `bus_stb` is low for at least one clock while `bus_cyc` stays high. Exactly two strobe phases occur within one `bus_cyc` assertion.
- R6: `bus_stb` is not raised for the write while `bus_ack` is still high from the read.
- R7: In the write phase `bus_we`=1 and `bus_adr` is unchanged. `bus_dat_w` equals the new value and `bus_sel`=`req_wr_sel`, so only those bytes change in the slave.
- R8: The clock after the write acknowledge, `bus_cyc` and `bus_stb` are both low.
- R9: `done` is high for exactly one clock, in the clock after the write acknowledge. `old_data` and `new_data` are valid at that point and hold in the following clock.
- R10: `req_valid` is ignored while `busy` is high. No second bus cycle follows, and the address offered during the transaction is not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start request, sampled in IDLE |
| req_addr | input | AW | Target address |
| req_rd_sel | input | DW/8 | Byte lanes for the read phase |
| req_wr_sel | input | DW/8 | Byte lanes for the write phase |
| req_op | input | 2 | 0 set, 1 clear, 2 masked replace, 3 keep |
| req_operand | input | DW | Operand of the operation |
| req_mask | input | DW | Bit mask for masked replace |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock completion strobe |
| old_data | output | DW | Value read (unselected bytes zero) |
| new_data | output | DW | Value written |
| bus_cyc | output | 1 | Bus cycle |
| bus_stb | output | 1 | Bus strobe |
| bus_we | output | 1 | Write enable |
| bus_adr | output | AW | Bus address |
| bus_sel | output | DW/8 | Byte selects |
| bus_dat_w | output | DW | Write data |
| bus_dat_r | input | DW | Read data |
| bus_ack | input | 1 | Slave acknowledge |

## Verification
A wrong state in the controller shows up at the bus within one clock. If the state leaves GAP too early, a strobe rises while the acknowledge is still high. If it skips GAP, there is a single long strobe instead of two separate phases. If it leaves WRITE at the wrong time, cycle stays up after the acknowledge, or `done` repeats. A fault in the data path shows up only when the transaction ends: `old_data`, `new_data` and the slave's stored word are all compared at the `done` clock. A slave that holds its acknowledge for several clocks and a slave that inserts wait states stretch GAP and READ, which exposes mistakes in the transition conditions.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef enum logic [1:0] {
        OP_SET  = 2'd0,
        OP_CLR  = 2'd1,
        OP_REPL = 2'd2,
        OP_KEEP = 2'd3
    } rmw_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_GAP   = 2'd2,
        ST_WRITE = 2'd3
    } rmw_state_e;

endpackage

// File: rtl/rmw_lane_mask.sv
module rmw_lane_mask #(
    parameter int DW = 32,
    parameter int SW = DW / 8
) (
    input  logic [SW-1:0] sel,
    output logic [DW-1:0] mask
);
    localparam int LANE = DW / SW;

    for (genvar i = 0; i < SW; i++) begin : g_lane
        assign mask[i*LANE +: LANE] = {LANE{sel[i]}};
    end
endmodule

// File: rtl/rmw_modify.sv
module rmw_modify
    import rmw_pkg::*;
#(
    parameter int DW = 32
) (
    input  rmw_op_e       op,
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] operand,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] new_val
);
    always_comb begin
        unique case (op)
            OP_SET:  new_val = old_val | operand;
            OP_CLR:  new_val = old_val & ~operand;
            OP_REPL: new_val = (old_val & ~mask) | (operand & mask);
            OP_KEEP: new_val = old_val;
        endcase
    end
endmodule

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
    import rmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       bus_ack,
    output rmw_state_e state,
    output logic       accept,
    output logic       read_ack,
    output logic       write_ack,
    output logic       cyc,
    output logic       stb,
    output logic       we
);
    rmw_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_READ;
            ST_READ:  if (bus_ack)   state_d = ST_GAP;
            ST_GAP:   if (!bus_ack)  state_d = ST_WRITE;
            ST_WRITE: if (bus_ack)   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        cyc       = 1'b0;
        stb       = 1'b0;
        we        = 1'b0;
        accept    = 1'b0;
        read_ack  = 1'b0;
        write_ack = 1'b0;
        unique case (state_q)
            ST_IDLE:  accept = req_valid;
            ST_READ: begin
                cyc      = 1'b1;
                stb      = 1'b1;
                read_ack = bus_ack;
            end
            ST_GAP:   cyc = 1'b1;
            ST_WRITE: begin
                cyc       = 1'b1;
                stb       = 1'b1;
                we        = 1'b1;
                write_ack = bus_ack;
            end
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/rmw_master.sv
module rmw_master
    import rmw_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 32,
    parameter int SW = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [SW-1:0] req_rd_sel,
    input  logic [SW-1:0] req_wr_sel,
    input  logic [1:0]    req_op,
    input  logic [DW-1:0] req_operand,
    input  logic [DW-1:0] req_mask,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] old_data,
    output logic [DW-1:0] new_data,
    output logic          bus_cyc,
    output logic          bus_stb,
    output logic          bus_we,
    output logic [AW-1:0] bus_adr,
    output logic [SW-1:0] bus_sel,
    output logic [DW-1:0] bus_dat_w,
    input  logic [DW-1:0] bus_dat_r,
    input  logic          bus_ack
);
    rmw_state_e    state;
    logic          accept, read_ack, write_ack;
    logic [AW-1:0] addr_q;
    logic [SW-1:0] rd_sel_q, wr_sel_q;
    rmw_op_e       op_q;
    logic [DW-1:0] operand_q, mask_q;
    logic [DW-1:0] rd_mask, captured, modified;
    logic [DW-1:0] old_q, new_q;
    logic          done_q;

    rmw_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .bus_ack   (bus_ack),
        .state     (state),
        .accept    (accept),
        .read_ack  (read_ack),
        .write_ack (write_ack),
        .cyc       (bus_cyc),
        .stb       (bus_stb),
        .we        (bus_we)
    );

    rmw_lane_mask #(.DW(DW), .SW(SW)) u_rd_mask (
        .sel  (rd_sel_q),
        .mask (rd_mask)
    );

    assign captured = bus_dat_r & rd_mask;

    rmw_modify #(.DW(DW)) u_modify (
        .op      (op_q),
        .old_val (captured),
        .operand (operand_q),
        .mask    (mask_q),
        .new_val (modified)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            rd_sel_q  <= '0;
            wr_sel_q  <= '0;
            op_q      <= OP_KEEP;
            operand_q <= '0;
            mask_q    <= '0;
        end else if (accept) begin
            addr_q    <= req_addr;
            rd_sel_q  <= req_rd_sel;
            wr_sel_q  <= req_wr_sel;
            op_q      <= rmw_op_e'(req_op);
            operand_q <= req_operand;
            mask_q    <= req_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_q <= '0;
            new_q <= '0;
        end else if (read_ack) begin
            old_q <= captured;
            new_q <= modified;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= write_ack;
    end

    always_comb begin
        bus_sel   = '0;
        bus_dat_w = '0;
        unique case (state)
            ST_IDLE:  bus_sel = '0;
            ST_READ:  bus_sel = rd_sel_q;
            ST_GAP:   bus_sel = '0;
            ST_WRITE: begin
                bus_sel   = wr_sel_q;
                bus_dat_w = new_q;
            end
        endcase
    end

    assign bus_adr  = addr_q;
    assign busy     = (state != ST_IDLE);
    assign done     = done_q;
    assign old_data = old_q;
    assign new_data = new_q;
endmodule

// File: rtl/rmw_master_chk.sv
module rmw_master_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_cyc,
    input logic          bus_stb,
    input logic          bus_we,
    input logic          bus_ack,
    input logic [AW-1:0] bus_adr,
    input logic          done
);
    // R2
    stb_in_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stb |-> bus_cyc);

    // R5
    read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_stb && !bus_we && bus_ack) |=> (bus_cyc && !bus_stb));

    // R6
    no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_stb && bus_ack) |=> !bus_stb);

    // R7
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && $past(bus_cyc)) |-> $stable(bus_adr));

    // R8
    end_of_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_stb && bus_we && bus_ack) |=> (!bus_cyc && !bus_stb));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(bus_we && bus_ack));
endmodule

bind rmw_master rmw_master_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_cyc (bus_cyc),
    .bus_stb (bus_stb),
    .bus_we  (bus_we),
    .bus_ack (bus_ack),
    .bus_adr (bus_adr),
    .done    (done)
);

// File: tb/rmw_master_bench.sv
module rmw_master_bench;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int SW = 4;

    typedef struct packed {
        logic [7:0]  addr;
        logic [3:0]  rsel;
        logic [3:0]  wsel;
        logic [1:0]  op;
        logic [31:0] operand;
        logic [31:0] mask;
        logic [31:0] init;
        logic [31:0] exp_old;
        logic [31:0] exp_new;
        logic [31:0] exp_mem;
    } vec_t;

    // R4 op codes: 0 set, 1 clear, 2 masked replace, 3 keep
    localparam vec_t VECS [6] = '{
        '{8'd1, 4'hF, 4'hF, 2'd0, 32'h000000F0, 32'h0, 32'h12345605, 32'h12345605, 32'h123456F5, 32'h123456F5},
        '{8'd2, 4'hF, 4'hF, 2'd1, 32'hFF000000, 32'h0, 32'hA5A5A5A5, 32'hA5A5A5A5, 32'h00A5A5A5, 32'h00A5A5A5},
        '{8'd3, 4'hF, 4'hF, 2'd2, 32'hDEADBEEF, 32'h0000FFFF, 32'h11112222, 32'h11112222, 32'h1111BEEF, 32'h1111BEEF},
        '{8'd4, 4'hF, 4'hF, 2'd3, 32'h5A5A5A5A, 32'h0, 32'hCAFEF00D, 32'hCAFEF00D, 32'hCAFEF00D, 32'hCAFEF00D},
        '{8'd5, 4'h3, 4'hF, 2'd0, 32'h01000000, 32'h0, 32'h77778888, 32'h00008888, 32'h01008888, 32'h01008888},
        '{8'd6, 4'hF, 4'h4, 2'd1, 32'hFFFFFFFF, 32'h0, 32'h12345678, 32'h12345678, 32'h00000000, 32'h12005678}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [SW-1:0] req_rd_sel = '0;
    logic [SW-1:0] req_wr_sel = '0;
    logic [1:0]    req_op = '0;
    logic [DW-1:0] req_operand = '0;
    logic [DW-1:0] req_mask = '0;
    logic          busy, done;
    logic [DW-1:0] old_data, new_data;
    logic          bus_cyc, bus_stb, bus_we;
    logic [AW-1:0] bus_adr;
    logic [SW-1:0] bus_sel;
    logic [DW-1:0] bus_dat_w, bus_dat_r;
    logic          bus_ack;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    rmw_master u_rmw_master (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_rd_sel(req_rd_sel), .req_wr_sel(req_wr_sel), .req_op(req_op),
        .req_operand(req_operand), .req_mask(req_mask), .busy(busy), .done(done),
        .old_data(old_data), .new_data(new_data), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
        .bus_we(bus_we), .bus_adr(bus_adr), .bus_sel(bus_sel), .bus_dat_w(bus_dat_w),
        .bus_dat_r(bus_dat_r), .bus_ack(bus_ack)
    );

    // slave model
    logic [31:0] mem [16];
    logic        pre_en = 1'b0;
    logic [3:0]  pre_addr = '0;
    logic [31:0] pre_data = '0;
    int          lat = 0;
    int          linger = 0;
    int          wcnt, lcnt;
    logic        ack_q;

    assign bus_ack   = ack_q;
    assign bus_dat_r = mem[bus_adr[3:0]];

    always_ff @(posedge clk) begin
        if (pre_en) mem[pre_addr] <= pre_data;
        if (!rst_n) begin
            ack_q <= 1'b0;
            wcnt  <= 0;
            lcnt  <= 0;
        end else if (ack_q) begin
            if (lcnt == 0) ack_q <= 1'b0;
            else           lcnt  <= lcnt - 1;
        end else if (bus_cyc && bus_stb) begin
            if (wcnt == lat) begin
                ack_q <= 1'b1;
                lcnt  <= linger;
                wcnt  <= 0;
                if (bus_we)
                    for (int b = 0; b < 4; b++)
                        if (bus_sel[b]) mem[bus_adr[3:0]][8*b +: 8] <= bus_dat_w[8*b +: 8];
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    // bus monitor, sampled just after each rising edge
    logic        prev_cyc = 1'b0, prev_stb = 1'b0;
    int          stb_rises = 0;
    bit          r6_bad = 1'b0;
    logic [7:0]  rd_adr, wr_adr;
    logic [3:0]  rd_sel, wr_sel;
    logic        rd_we, wr_we;
    logic [31:0] wr_dat;

    always begin
        int n;
        @(posedge clk);
        #1;
        n = (bus_cyc && !prev_cyc) ? 0 : stb_rises;
        if (bus_stb && !prev_stb) begin
            n++;
            if (bus_ack) r6_bad = 1'b1;
            if (n == 1) begin rd_adr = bus_adr; rd_sel = bus_sel; rd_we = bus_we; end
            if (n == 2) begin wr_adr = bus_adr; wr_sel = bus_sel; wr_we = bus_we; wr_dat = bus_dat_w; end
        end
        stb_rises = n;
        prev_cyc  = bus_cyc;
        prev_stb  = bus_stb;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [3:0] a, input logic [31:0] d);
        pre_en = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    task automatic run_rmw(input vec_t v, input bit poke);
        bit seen;
        preload(v.addr[3:0], v.init);
        r6_bad      = 1'b0;
        req_addr    = v.addr;
        req_rd_sel  = v.rsel;
        req_wr_sel  = v.wsel;
        req_op      = v.op;
        req_operand = v.operand;
        req_mask    = v.mask;
        req_valid   = 1'b1;
        @(negedge clk);
        if (poke) begin
            req_addr = 8'd9; req_op = 2'd0; req_operand = '1;
            req_rd_sel = 4'hF; req_wr_sel = 4'hF;
        end else begin
            req_valid = 1'b0;
        end
        seen = 1'b0;
        for (int g = 0; g < 200 && !seen; g++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
        req_valid = 1'b0;
        chk("R9 done seen", {31'd0, seen}, 32'd1);
        chk("R2 read we", {31'd0, rd_we}, 32'd0);
        chk("R2 read adr", {24'd0, rd_adr}, {24'd0, v.addr});
        chk("R2 read sel", {28'd0, rd_sel}, {28'd0, v.rsel});
        chk("R3 old_data", old_data, v.exp_old);
        chk("R4 new_data", new_data, v.exp_new);
        chk("R5 two strobes", stb_rises, 32'd2);
        chk("R6 no early write strobe", {31'd0, r6_bad}, 32'd0);
        chk("R7 write we", {31'd0, wr_we}, 32'd1);
        chk("R7 write adr", {24'd0, wr_adr}, {24'd0, v.addr});
        chk("R7 write sel", {28'd0, wr_sel}, {28'd0, v.wsel});
        chk("R7 write data", wr_dat, v.exp_new);
        chk("R7 slave word", mem[v.addr[3:0]], v.exp_mem);
        chk("R8 cyc/stb low", {30'd0, bus_cyc, bus_stb}, 32'd0);
        @(negedge clk);
        chk("R9 done one clock", {31'd0, done}, 32'd0);
        chk("R9 old held", old_data, v.exp_old);
        chk("R9 new held", new_data, v.exp_new);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog all-R actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 in reset", {27'd0, bus_cyc, bus_stb, bus_we, busy, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {27'd0, bus_cyc, bus_stb, bus_we, busy, done}, 32'd0);

        for (int i = 0; i < 6; i++) run_rmw(VECS[i], 1'b0);

        // R5 R3 slave with wait states
        lat = 3;
        v = '{8'd8, 4'hF, 4'hF, 2'd2, 32'hAB000000, 32'hFF000000, 32'h00112233,
              32'h00112233, 32'hAB112233, 32'hAB112233};
        run_rmw(v, 1'b0);
        lat = 0;

        // R6 slave holds acknowledge for three extra clocks
        linger = 3;
        v = '{8'd10, 4'hF, 4'hF, 2'd0, 32'h80000001, 32'h0, 32'h00000000,
              32'h00000000, 32'h80000001, 32'h80000001};
        run_rmw(v, 1'b0);
        linger = 0;

        // R10 request held high during a transaction
        preload(4'd9, 32'h00000055);
        v = '{8'd7, 4'hF, 4'hF, 2'd1, 32'h0000000F, 32'h0, 32'h0F0F0F0F,
              32'h0F0F0F0F, 32'h0F0F0F00, 32'h0F0F0F00};
        run_rmw(v, 1'b1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R10 no second cycle", {31'd0, bus_cyc}, 32'd0);
        end
        chk("R10 other word untouched", mem[9], 32'h00000055);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule